// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block merges eight level-sensitive interrupt requests onto one request line to a processor. When an unmasked request is allowed, it raises `intr`. The processor answers with a one-cycle `inta` pulse. On the next cycle the block returns an 8-bit vector number, marked by `vecValid`. The vector combines a programmable base with the number of the winning input.

An in-service register records which requests the processor is handling. Input 0 has the highest priority and input 7 the lowest. While a request is in service, it holds back itself and every lower-priority request, so only higher-priority requests can nest on top of it. Software frees the highest-priority in-service level with an end-of-interrupt command. Alternatively, an auto-EOI mode leaves the in-service register untouched on every acknowledge.

Software reaches the block through a small register port with four addresses:

| Address | Name | Write | Read |
|---|---|---|---|
| 0 | mask | bit i = 1 masks input i | mask value |
| 1 | vector base | bits 7..3 kept | bits 7..3, low bits 0 |
| 2 | command | bit 0 = 1 issues a non-specific EOI | 0 |
| 3 | mode | bit 0 = auto-EOI | mode bit |

Reads are combinational from `regAddr`.

Top module: `pic_vectored`

## Requirements
- R1: After reset, `intr` and `vecValid` are low, the mask reads 0xFF (all inputs masked), the vector base reads 0x00 and the mode register reads 0x00.
- R2: Request inputs are sampled on every rising clock edge. `intr` rises in the cycle after the edge that first samples an unmasked, allowed request, and not before that edge.
- R3: Writing address 0 sets the mask, where bit i = 1 masks input i. A masked request never raises `intr` and is never chosen by an acknowledge. Address 0 reads back the written mask.
- R4: An `inta` pulse of one cycle is answered in the following cycle by `vecValid` high for exactly one cycle, with the vector on `vecOut`.
- R5: The vector is {base[7:3], input number[2:0]}. Writing address 1 keeps only bits 7..3, and a read of address 1 returns them with bits 2..0 zero. For example, base 0xD0 with input 3 gives 0xD3.
- R6: On an acknowledge, the lowest-numbered allowed, unmasked request sampled at that moment wins.
- R7: An acknowledge outside auto-EOI mode sets the in-service bit of the winner. While bit k is the lowest set in-service bit, requests k..7 cannot raise `intr` and stay pending. Requests 0..k-1 still raise it.
- R8: Writing address 2 with bit 0 = 1 clears only the lowest-numbered set in-service bit. A request still held high after its EOI interrupts again with the same vector.
- R9: With address 3 bit 0 = 1 (auto-EOI), an acknowledge sets no in-service bit. A held request therefore keeps `intr` high and is acknowledged again, and lower-priority requests are not blocked.
- R10: An acknowledge with no allowed request returns the spurious vector {base, 3'd7} and sets no in-service bit. A later request on input 7 still raises `intr`.
- R11: The sampled request register cannot be read: address 2 reads 0x00 whatever requests are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | NUM_IRQ | Level-sensitive request inputs, bit 0 highest priority |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 mask, 1 base, 2 command, 3 mode |
| regWdata | input | VEC_W | Register write data |
| regRdata | output | VEC_W | Register read data for `regAddr` |
| inta | input | 1 | One-cycle interrupt acknowledge from the processor |
| intr | output | 1 | Interrupt request to the processor |
| vecOut | output | VEC_W | Vector number, valid while `vecValid` is high |
| vecValid | output | 1 | One-cycle strobe marking the vector |

## Verification
The bench builds the block with its defaults, NUM_IRQ = 8 and VEC_W = 8. This gives a 5-bit base and a 3-bit input number, so input 7 serves as both the lowest real priority and the spurious code.

With eight levels, the bench can stack two in-service levels and show that an EOI frees only the higher one. It can also run the spurious path and show that input 7 is not left blocked afterwards. Expected vectors go into a scoreboard queue when each acknowledge is issued and are compared when the vector strobe appears.

// File: rtl/pic_pkg.sv
package pic_pkg;

  // Register addresses, one-hot decoded in the control module.
  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_BASE = 2'd1;
  localparam logic [1:0] ADDR_CMD  = 2'd2;
  localparam logic [1:0] ADDR_MODE = 2'd3;

  // Per-cycle strobes from the control module to the datapath.
  typedef struct packed {
    logic wrMask;
    logic wrBase;
    logic wrMode;
    logic eoi;
    logic ack;
  } ctrlStrobeT;

endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int BASE_W = VEC_W - IDX_W
) (
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic               cmdBit,
  input  logic               inta,
  input  logic [NUM_IRQ-1:0] maskReg,
  input  logic [BASE_W-1:0]  baseReg,
  input  logic               autoEoi,
  output ctrlStrobeT         strb,
  output logic [VEC_W-1:0]   regRdata
);

  // Decode writes and the acknowledge into one strobe struct.
  always_comb begin
    strb.wrMask = regWr && (regAddr == ADDR_MASK);
    strb.wrBase = regWr && (regAddr == ADDR_BASE);
    strb.wrMode = regWr && (regAddr == ADDR_MODE);
    strb.eoi    = regWr && (regAddr == ADDR_CMD) && cmdBit;
    strb.ack    = inta;
  end

  // Read mux. The request and in-service registers are never exposed.
  always_comb begin
    case (regAddr)
      ADDR_MASK: regRdata = VEC_W'(maskReg);
      ADDR_BASE: regRdata = {baseReg, {IDX_W{1'b0}}};
      ADDR_MODE: regRdata = VEC_W'(autoEoi);
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int BASE_W = VEC_W - IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  ctrlStrobeT         strb,
  input  logic [VEC_W-1:0]   wdata,
  output logic               intr,
  output logic [VEC_W-1:0]   vecOut,
  output logic               vecValid,
  output logic [NUM_IRQ-1:0] maskReg,
  output logic [BASE_W-1:0]  baseReg,
  output logic               autoEoi
);

  logic [NUM_IRQ-1:0] reqQ;      // sampled request levels
  logic [NUM_IRQ-1:0] inSvc;     // in-service bits
  logic [NUM_IRQ-1:0] svcLow;    // lowest set in-service bit, one-hot
  logic [NUM_IRQ-1:0] allowMsk;  // priority levels above the ceiling
  logic [NUM_IRQ-1:0] cand;      // allowed, unmasked, pending
  logic [IDX_W-1:0]   winIdx;
  logic               winAny;
  logic [NUM_IRQ-1:0] setSvc;
  logic [NUM_IRQ-1:0] clrSvc;

  // Software-visible configuration and sampled requests.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ    <= '0;
      maskReg <= '1;
      baseReg <= '0;
      autoEoi <= 1'b0;
    end else begin
      reqQ <= irqReq;
      if (strb.wrMask) maskReg <= wdata[NUM_IRQ-1:0];
      if (strb.wrBase) baseReg <= wdata[VEC_W-1:IDX_W];
      if (strb.wrMode) autoEoi <= wdata[0];
    end
  end

  // Priority ceiling from the in-service register.
  always_comb begin
    svcLow   = inSvc & (~inSvc + NUM_IRQ'(1));
    allowMsk = (inSvc == '0) ? '1 : (svcLow - NUM_IRQ'(1));
    cand     = reqQ & ~maskReg & allowMsk;
  end

  // Fixed-priority pick: lowest index wins, otherwise the last input.
  always_comb begin
    winIdx = IDX_W'(NUM_IRQ - 1);
    winAny = 1'b0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (cand[i]) begin
        winIdx = IDX_W'(i);
        winAny = 1'b1;
      end
    end
  end

  assign intr = winAny;

  always_comb begin
    setSvc = '0;
    if (strb.ack && winAny && !autoEoi) setSvc[winIdx] = 1'b1;
    clrSvc = strb.eoi ? svcLow : '0;
  end

  // One register per in-service bit: clear first, then set.
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_svc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) inSvc[g] <= 1'b0;
      else       inSvc[g] <= (inSvc[g] & ~clrSvc[g]) | setSvc[g];
    end
  end

  // Vector output stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      vecValid <= strb.ack;
      if (strb.ack) vecOut <= {baseReg, winIdx};
    end
  end

endmodule

// File: rtl/pic_vectored.sv
module pic_vectored
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int BASE_W = VEC_W - IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [VEC_W-1:0]   regWdata,
  output logic [VEC_W-1:0]   regRdata,
  input  logic               inta,
  output logic               intr,
  output logic [VEC_W-1:0]   vecOut,
  output logic               vecValid
);

  ctrlStrobeT         strb;
  logic [NUM_IRQ-1:0] maskReg;
  logic [BASE_W-1:0]  baseReg;
  logic               autoEoi;

  pic_ctrl #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) i_ctrl (
    .regWr    (regWr),
    .regAddr  (regAddr),
    .cmdBit   (regWdata[0]),
    .inta     (inta),
    .maskReg  (maskReg),
    .baseReg  (baseReg),
    .autoEoi  (autoEoi),
    .strb     (strb),
    .regRdata (regRdata)
  );

  pic_datapath #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .irqReq   (irqReq),
    .strb     (strb),
    .wdata    (regWdata),
    .intr     (intr),
    .vecOut   (vecOut),
    .vecValid (vecValid),
    .maskReg  (maskReg),
    .baseReg  (baseReg),
    .autoEoi  (autoEoi)
  );

endmodule

// File: rtl/pic_vectored_chk.sv
module pic_vectored_chk #(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int BASE_W = VEC_W - IDX_W
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_IRQ-1:0] irqReq,
  input logic               regWr,
  input logic [1:0]         regAddr,
  input logic [VEC_W-1:0]   regWdata,
  input logic               inta,
  input logic               intr,
  input logic [VEC_W-1:0]   vecOut,
  input logic               vecValid,
  input logic [NUM_IRQ-1:0] maskReg,
  input logic [BASE_W-1:0]  baseReg
);

  // R4: an acknowledge is answered by a vector strobe one cycle later.
  p_ack_answered_r4: assert property (@(posedge clk) disable iff (!rstN)
    inta |=> vecValid);

  // R4: no vector strobe without an acknowledge in the cycle before.
  p_no_stray_vector_r4: assert property (@(posedge clk) disable iff (!rstN)
    !inta |=> !vecValid);

  // R5: the upper vector bits equal the base in force at the acknowledge.
  p_vector_base_r5: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecOut[VEC_W-1:IDX_W] == $past(baseReg)));

  // R3: intr needs an unmasked request sampled on the previous edge.
  p_intr_needs_request_r3: assert property (@(posedge clk) disable iff (!rstN)
    intr |-> (($past(irqReq) & ~maskReg) != '0));

  // R3: a mask write takes the written value.
  p_mask_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd0) |=> (maskReg == $past(regWdata[NUM_IRQ-1:0])));

endmodule

bind pic_vectored pic_vectored_chk #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqReq   (irqReq),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .inta     (inta),
  .intr     (intr),
  .vecOut   (vecOut),
  .vecValid (vecValid),
  .maskReg  (maskReg),
  .baseReg  (baseReg)
);

// File: tb/test_pic_vectored.sv
`timescale 1ns/1ps
module test_pic_vectored;
  localparam int NUM_IRQ = 8;
  localparam int VEC_W   = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [7:0]       irqReq = '0;
  logic             regWr = 1'b0;
  logic [1:0]       regAddr = '0;
  logic [7:0]       regWdata = '0;
  logic [7:0]       regRdata;
  logic             inta = 1'b0;
  logic             intr;
  logic [7:0]       vecOut;
  logic             vecValid;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] expV;
  string      expT;
  logic [7:0] rd;

  always #5 clk = ~clk;

  pic_vectored #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) i_pic_vectored (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .inta(inta), .intr(intr),
    .vecOut(vecOut), .vecValid(vecValid)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  // Driver: queues the expected vector, then pulses inta for one cycle.
  task automatic ack(input string tag, input logic [7:0] exp);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
  endtask

  // Drive a new request level; returns once it has been sampled.
  task automatic setReq(input logic [7:0] v);
    @(negedge clk);
    irqReq = v;
    @(negedge clk);
  endtask

  task automatic eoi();
    regWrite(2'd2, 8'h01);
  endtask

  task automatic checkIntr(input string tag, input logic exp);
    check(tag, {7'b0, intr}, {7'b0, exp});
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Monitor: pops the scoreboard on every vector strobe.
  always @(negedge clk) begin
    if (rstN && vecValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected vector actual 0x%0h expected none", vecOut);
      end else begin
        expV = expQ.pop_front();
        expT = tagQ.pop_front();
        if (vecOut !== expV) begin
          errors++;
          $display("FAIL %s actual 0x%0h expected 0x%0h", expT, vecOut, expV);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state.
    checkIntr("R1 intr after reset", 1'b0);
    check("R1 vecValid after reset", {7'b0, vecValid}, 8'h00);
    regRead(2'd0, rd); check("R1 mask reset", rd, 8'hFF);
    regRead(2'd1, rd); check("R1 base reset", rd, 8'h00);
    regRead(2'd3, rd); check("R1 mode reset", rd, 8'h00);

    // R5: base keeps bits 7..3 only.
    regWrite(2'd1, 8'hD7);
    regRead(2'd1, rd); check("R5 base readback", rd, 8'hD0);

    // R3: masked request stays quiet, then unmasking raises intr.
    setReq(8'h08);
    @(negedge clk);
    checkIntr("R3 masked request quiet", 1'b0);
    regWrite(2'd0, 8'h00);
    regRead(2'd0, rd); check("R3 mask readback", rd, 8'h00);
    checkIntr("R3 unmasked request raises intr", 1'b1);
    setReq(8'h00);
    checkIntr("R2 intr low without request", 1'b0);

    // R2: intr follows the first sampling edge.
    @(negedge clk);
    irqReq = 8'h08;
    #1 checkIntr("R2 intr not before sampling edge", 1'b0);
    @(negedge clk);
    checkIntr("R2 intr after sampling edge", 1'b1);

    // R4 R5: acknowledge input 3 under base 0xD0.
    ack("R5 vector for input 3", 8'hD3);
    @(negedge clk);
    check("R4 vecValid one cycle only", {7'b0, vecValid}, 8'h00);
    checkIntr("R7 serviced request blocks itself", 1'b0);
    regRead(2'd2, rd); check("R11 request register unreadable", rd, 8'h00);

    // R7: lower priority blocked, higher nests.
    setReq(8'h28);
    checkIntr("R7 lower priority blocked", 1'b0);
    setReq(8'h2E);
    checkIntr("R7 higher priority nests", 1'b1);
    ack("R6 lowest index wins among 1 2 5", 8'hD1);
    checkIntr("R7 in-service 1 blocks 2", 1'b0);

    // R8: EOI clears only the highest-priority in-service bit.
    setReq(8'h2C);
    eoi();
    checkIntr("R8 EOI frees level 1 so 2 interrupts", 1'b1);
    ack("R6 input 2 below service level 3", 8'hD2);
    setReq(8'h28);
    eoi();
    checkIntr("R8 EOI cleared 2 only, 3 still blocks", 1'b0);
    eoi();
    checkIntr("R8 held request re-interrupts", 1'b1);
    ack("R8 same vector after EOI", 8'hD3);
    eoi();
    setReq(8'h20);
    ack("R6 remaining input 5", 8'hD5);
    eoi();
    setReq(8'h00);
    checkIntr("R8 all clear", 1'b0);

    // R10: request gone before acknowledge.
    setReq(8'h10);
    checkIntr("R10 request seen", 1'b1);
    setReq(8'h00);
    ack("R10 spurious vector", 8'hD7);
    setReq(8'h80);
    checkIntr("R10 spurious left input 7 unblocked", 1'b1);
    ack("R10 real input 7", 8'hD7);
    eoi();
    setReq(8'h00);

    // R3 R6: masked higher-priority input is skipped.
    regWrite(2'd0, 8'h02);
    setReq(8'h42);
    ack("R3 masked input 1 skipped", 8'hD6);
    eoi();
    regWrite(2'd0, 8'h00);
    setReq(8'h00);

    // R5: new base.
    regWrite(2'd1, 8'h48);
    regRead(2'd1, rd); check("R5 base readback 0x48", rd, 8'h48);
    setReq(8'h01);
    ack("R5 vector base 0x48 input 0", 8'h48);
    eoi();
    setReq(8'h00);

    // R9: auto-EOI mode.
    regWrite(2'd3, 8'h01);
    regRead(2'd3, rd); check("R9 mode readback", rd, 8'h01);
    setReq(8'h04);
    ack("R9 first acknowledge", 8'h4A);
    checkIntr("R9 held request keeps intr", 1'b1);
    ack("R9 repeat acknowledge", 8'h4A);
    setReq(8'h20);
    checkIntr("R9 lower priority not blocked", 1'b1);
    ack("R9 lower input 5", 8'h4D);
    setReq(8'h00);
    regWrite(2'd3, 8'h00);
    checkIntr("R9 idle at end", 1'b0);

    repeat (2) @(negedge clk);
    check("R4 scoreboard drained", 8'(expQ.size()), 8'h00);
    summary();
    $finish;
  end

endmodule